// File: doc/BRIEF.md
# Multi-slot compare alarm scheduler

This block shares one compare value among eight one-shot alarm slots. Each slot holds a target tick count and an arm bit. The block watches a free-running tick counter that comes from an external timebase. It keeps a single scheduled value, which is the armed target nearest ahead of the counter. When the counter moves one past that value, the block reports every armed slot whose target equals it and disarms those slots. It then picks the next nearest target.

Software-facing logic writes a slot through a write port (index, target, arm) or disarms it through a disable port. Either action normally triggers a fresh search for the nearest target. A no-schedule flag lets several slots be loaded back to back and searched only once. The counter and the routing of the match pulses to interrupts live outside this block.

Top module: `cmp_alarm_sched`

## Requirements
- R1: There are eight slots, addressed by index 0 to 7. A write or disable with an index of 8 or more changes no slot and triggers no search.
- R2: A match fires on a tick where `cnt_i` equals the scheduled value plus one, so it comes one tick after the target count. Bit i of `match_o` is slot i. `match_o` is a one-clock pulse in the clock cycle after that tick.
- R3: Every armed slot whose target equals the scheduled value is reported in the same pulse.
- R4: A reported slot is disarmed, so it fires once and does not repeat until it is written again.
- R5: The search measures each armed slot's distance as the unsigned modulo-2^32 difference target − (`cnt_i`+1). It picks the smallest distance. On equal distance the higher slot index wins. Targets on both sides of the counter wrap are ordered correctly.
- R6: If `cnt_i` equals the scheduled value, no search result is committed, so the pending match still fires.
- R7: If no slot is armed when a search completes, the scheduled value becomes (`cnt_i`+1)−2.
- R8: A valid write or disable triggers a search unless `no_sched_i` is high in that cycle. A match always triggers a search.
- R9: The disable port disarms the addressed slot. A disarmed slot never appears in `match_o`.
- R10: A slot write in the same cycle as a match takes effect after the match is handled. Re-arming the slot being reported therefore leaves it armed with the new target.
- R11: After reset all slots are disarmed, `match_o` is zero, and the scheduled value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe: `cnt_i` has just advanced |
| cnt_i | input | 32 | Current tick count from the timebase |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | 4 | Slot index for the write |
| wr_tgt_i | input | 32 | Target count to store |
| wr_arm_i | input | 1 | Arm bit to store |
| dis_en_i | input | 1 | Slot disable strobe |
| dis_idx_i | input | 4 | Slot index for the disable |
| no_sched_i | input | 1 | Suppress the search after a write or disable |
| match_o | output | 8 | One-cycle pulse of matched slots |

## Verification
A match and a slot write can land in the same clock cycle. Both then update the arm bits and both ask for a new search.

The bench provokes this in two ways:
- It re-arms the very slot being reported in the tick that reports it. It then judges the order by a second pulse on that slot at the new target plus one. A wrong order would lose that pulse.
- It writes a nearer slot while the counter sits on the scheduled value. It judges by whether the older target still fires first.

// File: rtl/cmp_alarm_sched.sv
module cmp_alarm_sched #(
  parameter int SLOTS = 8,
  parameter int CW    = 32,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [CW-1:0]    wr_tgt_i,
  input  logic             wr_arm_i,
  input  logic             dis_en_i,
  input  logic [IW-1:0]    dis_idx_i,
  input  logic             no_sched_i,
  output logic [SLOTS-1:0] match_o
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);
  localparam logic [IW-1:0] LIM = IW'(SLOTS);

  logic [CW-1:0]    tgt_q [SLOTS];
  logic [CW-1:0]    tgt_n [SLOTS];
  logic [SLOTS-1:0] en_q, en_n, hit_vec, match_q;
  logic [CW-1:0]    sched_q, sched_n, cur1, best_d, best_t;
  logic             hit, wr_ok, dis_ok, found, resched;

  assign hit     = tick_i && (cnt_i == sched_q + ONE);
  assign wr_ok   = wr_en_i && (wr_idx_i < LIM);
  assign dis_ok  = dis_en_i && (dis_idx_i < LIM);
  assign cur1    = cnt_i + ONE;
  assign resched = hit || ((wr_ok || dis_ok) && !no_sched_i);
  assign match_o = match_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    assign hit_vec[g] = hit && en_q[g] && (tgt_q[g] == sched_q);
  end

  always_comb begin
    en_n = en_q & ~hit_vec;
    for (int i = 0; i < SLOTS; i++) begin
      tgt_n[i] = tgt_q[i];
      if (wr_ok && wr_idx_i == IW'(i)) begin
        tgt_n[i] = wr_tgt_i;
        en_n[i]  = wr_arm_i;
      end
      if (dis_ok && dis_idx_i == IW'(i)) en_n[i] = 1'b0;
    end
  end

  always_comb begin : pick
    logic [CW-1:0] d;
    d      = '0;
    best_d = '1;
    best_t = '0;
    found  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      d = tgt_n[i] - cur1;
      if (en_n[i] && d <= best_d) begin
        best_d = d;
        best_t = tgt_n[i];
        found  = 1'b1;
      end
    end
    sched_n = found ? best_t : cur1 - TWO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      sched_q <= '1;
      match_q <= '0;
      for (int i = 0; i < SLOTS; i++) tgt_q[i] <= '0;
    end else begin
      en_q    <= en_n;
      tgt_q   <= tgt_n;
      match_q <= hit_vec;
      if (resched && cnt_i != sched_q) sched_q <= sched_n;
    end
  end

  a_r1_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i >= LIM && !dis_en_i && !tick_i) |=> ($stable(en_q) && $stable(sched_q)));

  a_r2_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_o) |-> $past(tick_i));

  a_r4_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    ((|match_o) && !$past(wr_en_i)) |-> ((match_o & en_q) == '0));

  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == sched_q) |=> $stable(sched_q));

  a_r8_no_sched: assert property (@(posedge clk) disable iff (!rst_n)
    (no_sched_i && !tick_i) |=> $stable(sched_q));

endmodule

// File: tb/tb_cmp_alarm_sched.sv
module tb_cmp_alarm_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] cnt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tgt = '0;
  logic        wr_arm = 1'b0;
  logic        dis_en = 1'b0;
  logic [3:0]  dis_idx = '0;
  logic        no_sched = 1'b0;
  logic [7:0]  match;
  int          errs = 0;
  int          nchk = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cmp_alarm_sched dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_i(cnt),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tgt_i(wr_tgt), .wr_arm_i(wr_arm),
    .dis_en_i(dis_en), .dis_idx_i(dis_idx), .no_sched_i(no_sched),
    .match_o(match)
  );

  localparam logic [31:0] V_START [6] = '{32'd100, 32'd200, 32'hFFFF_FFFC, 32'hFFFF_FFFE, 32'd1000, 32'd50};
  localparam logic [3:0]  V_IDX   [6] = '{4'd0, 4'd7, 4'd3, 4'd5, 4'd2, 4'd6};
  localparam logic [31:0] V_TGT   [6] = '{32'd105, 32'd200, 32'hFFFF_FFFF, 32'd3, 32'd1001, 32'd60};

  task automatic chk(input logic [7:0] exp, input string req);
    nchk++;
    if (match !== exp) begin
      errs++;
      $display("FAIL %s cnt=%0d actual=%h expected=%h", req, cnt, match, exp);
    end
  endtask

  task automatic tk(input logic [31:0] v);
    @(negedge clk);
    cnt  = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tk_chk(input logic [31:0] v, input logic [7:0] exp, input string req);
    tk(v);
    chk(exp, req);
  endtask

  task automatic run(input logic [31:0] from, input logic [31:0] to,
                     input logic [31:0] at_a, input logic [7:0] m_a,
                     input logic [31:0] at_b, input logic [7:0] m_b, input string req);
    for (logic [31:0] v = from; v <= to; v++)
      tk_chk(v, (v == at_a) ? m_a : ((v == at_b) ? m_b : 8'h00), req);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] tgt, input logic arm, input logic ns);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_tgt = tgt; wr_arm = arm; no_sched = ns;
    @(negedge clk);
    wr_en = 1'b0; no_sched = 1'b0;
  endtask

  task automatic dis(input logic [3:0] idx, input logic ns);
    @(negedge clk);
    dis_en = 1'b1; dis_idx = idx; no_sched = ns;
    @(negedge clk);
    dis_en = 1'b0; no_sched = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(8'h00, "R11 reset");
    rst_n = 1'b1;
    tk_chk(32'd1, 8'h00, "R11 idle");
    tk_chk(32'd2, 8'h00, "R11 idle");

    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      cnt = V_START[n];
      wr(V_IDX[n], V_TGT[n], 1'b1, 1'b0);
      for (int k = 1; k <= 12; k++) begin
        logic [31:0] v;
        v = V_START[n] + 32'(k);
        tk_chk(v, (v == V_TGT[n] + 32'd1) ? (8'h01 << V_IDX[n]) : 8'h00, "R2 R5 vector");
      end
    end

    cnt = 32'd300;
    wr(4'd8, 32'd305, 1'b1, 1'b0);
    wr(4'd15, 32'd303, 1'b1, 1'b0);
    run(32'd301, 32'd310, 32'd0, 8'h00, 32'd0, 8'h00, "R1 bad index");

    cnt = 32'd400;
    wr(4'd1, 32'd410, 1'b1, 1'b0);
    wr(4'd4, 32'd410, 1'b1, 1'b0);
    run(32'd401, 32'd412, 32'd411, 8'h12, 32'd0, 8'h00, "R3 shared target");

    cnt = 32'd500;
    wr(4'd0, 32'd520, 1'b1, 1'b0);
    wr(4'd1, 32'd510, 1'b1, 1'b0);
    run(32'd501, 32'd525, 32'd511, 8'h02, 32'd521, 8'h01, "R5 R4 nearest then next");

    cnt = 32'd600;
    wr(4'd2, 32'd605, 1'b1, 1'b1);
    run(32'd601, 32'd610, 32'd0, 8'h00, 32'd0, 8'h00, "R8 no_sched");
    wr(4'd3, 32'd615, 1'b1, 1'b0);
    run(32'd611, 32'd617, 32'd616, 8'h08, 32'd0, 8'h00, "R8 write schedules");

    cnt = 32'd700;
    dis(4'd2, 1'b0);
    cnt = 32'd710;
    wr(4'd5, 32'd720, 1'b1, 1'b0);
    dis(4'd5, 1'b0);
    run(32'd711, 32'd725, 32'd0, 8'h00, 32'd0, 8'h00, "R9 disable");

    cnt = 32'd790;
    wr(4'd0, 32'd800, 1'b1, 1'b0);
    run(32'd791, 32'd800, 32'd0, 8'h00, 32'd0, 8'h00, "R6 approach");
    wr(4'd1, 32'd802, 1'b1, 1'b0);
    run(32'd801, 32'd804, 32'd801, 8'h01, 32'd803, 8'h02, "R6 pending kept");

    cnt = 32'd890;
    wr(4'd4, 32'd900, 1'b1, 1'b0);
    run(32'd891, 32'd900, 32'd0, 8'h00, 32'd0, 8'h00, "R10 approach");
    @(negedge clk);
    cnt = 32'd901; tick = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd4; wr_tgt = 32'd905; wr_arm = 1'b1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk(8'h10, "R10 match with write");
    run(32'd902, 32'd907, 32'd906, 8'h10, 32'd0, 8'h00, "R10 rearmed slot");

    cnt = 32'd907;
    wr(4'd0, 32'd920, 1'b1, 1'b1);
    tk_chk(32'd906, 8'h00, "R7 empty wake");
    run(32'd907, 32'd922, 32'd921, 8'h01, 32'd0, 8'h00, "R7 idle value");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule